// File: doc/BRIEF.md
# Tagged FIFO Communication Cell

This block is a single inter-thread communication cell built around a small circular queue. Two tag bits, E (empty) and F (full), track the queue state, and a third tag bit, T, is kept for software. Requesters reach the cell through a view code that chooses how an access acts. The bypass view inspects or patches queue contents without moving any pointer. The control view reads or writes a packed status word. The two empty/full views push and pop; one of them blocks and the other does not.

Each access presents a view code, a read strobe or a write strobe, write data and a requester identifier. When a blocking access cannot complete, the cell replies with a block indication and sets the requester's bit in a blocked bitmap. When a later empty/full access completes, the cell issues a one-cycle wake pulse and clears the bitmap, so that the waiting requesters can retry. Halting and resuming the requesters is left to the surrounding logic.

Top module: `tagged_fifo_cell`

## Requirements
- R1: After reset the queue is empty, E=1, F=0, T=0, head and occupancy are zero, all storage entries are zero and the blocked bitmap is zero.
- R2: A write in view 2 (blocking) or 3 (non-blocking) that completes clears E, stores the data at position (head + occupancy) mod DEPTH when occupancy < DEPTH and increments occupancy, and sets F once occupancy equals DEPTH.
- R3: A read in view 2 or 3 that completes clears F. It returns the head entry, advances head mod DEPTH and decrements occupancy, or returns zero when occupancy is already zero. It sets E whenever the resulting occupancy is zero.
- R4: A read in view 2 while E=1 does not complete: it answers with a block indication, sets bit req_id of the blocked bitmap, clears F, and leaves the data and pointers unchanged.
- R5: A write in view 2 while F=1 does not complete: it answers with a block indication, sets bit req_id of the bitmap, clears E and stores nothing.
- R6: An empty/full access that completes while the bitmap is nonzero raises wake for exactly one cycle, and the bitmap reads zero in that same cycle.
- R7: A write in view 1 loads T from bit 16, F from bit 1 and E from bit 0 of the write data, and clears the occupancy when the new E is 1.
- R8: A read in view 1 returns log2(DEPTH) at bits 31:28, the occupancy at bits 18 upward, a 1 at bit 17 (queue mode), T at bit 16, F at bit 1 and E at bit 0, with all other bits zero.
- R9: A read in view 0 returns the head entry and leaves pointers, tags and the bitmap unchanged.
- R10: A write in view 0 replaces the entry at (head + occupancy - 1) mod DEPTH when occupancy is nonzero. At zero occupancy it has no effect.
- R11: Views 4 and 5 (counting-semaphore views, which are inactive while the cell is in queue mode) and the unused codes 6 and 7 return zero on a read and change nothing on a write.
- R12: When rd_en and wr_en are high together, only the read is performed.
- R13: A non-blocking write in view 3 while the queue is full still completes: it stores nothing, keeps F=1, clears E and wakes any blocked requesters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wr_en | input | 1 | Write strobe |
| view | input | 3 | View code 0..7 |
| wr_data | input | DW | Write data |
| req_id | input | IDW | Requester identifier |
| rsp_valid | output | 1 | Read result valid (one cycle after a completed read) |
| rsp_blocked | output | 1 | Block indication (one cycle after a blocked access) |
| rsp_data | output | DW | Read result |
| blocked_map | output | NREQ | Bitmap of blocked requesters |
| wake | output | 1 | Pulse: blocked requesters may retry |

## Verification
All results arrive exactly one clock after the edge that samples the strobe. rsp_valid or rsp_blocked, rsp_data, wake and blocked_map all change on that edge, and any change to tag state becomes visible to a control-view read issued in the following cycle. The driver applies each access on a falling edge and holds it for one cycle. It queues the expected response from an independent model of the cell. The monitor compares the response on the next falling edge, which is half a cycle after the outputs settle. The driver checks wake and the bitmap on that same falling edge.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  typedef enum logic [2:0] {
    VW_PEEK   = 3'd0,
    VW_CTRL   = 3'd1,
    VW_EF_BLK = 3'd2,
    VW_EF_TRY = 3'd3,
    VW_SEM_B  = 3'd4,
    VW_SEM_T  = 3'd5,
    VW_RSV6   = 3'd6,
    VW_RSV7   = 3'd7
  } view_e;

  localparam int CTRL_DEPTH_LSB = 28;
  localparam int CTRL_OCC_LSB   = 18;
  localparam int CTRL_MODE_BIT  = 17;
  localparam int CTRL_T_BIT     = 16;
  localparam int CTRL_F_BIT     = 1;
  localparam int CTRL_E_BIT     = 0;
endpackage

// File: rtl/tfc_storage.sv
module tfc_storage #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[i] <= '0;
      else if (hit) mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tfc_waitlist.sv
module tfc_waitlist #(
  parameter int NREQ = 4,
  parameter int IDW  = $clog2(NREQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            block_en,
  input  logic [IDW-1:0]  block_id,
  input  logic            release_en,
  output logic [NREQ-1:0] map_q,
  output logic            wake_q
);
  logic [NREQ-1:0] map_d;
  logic            wake_d;

  always_comb begin
    map_d  = map_q;
    wake_d = 1'b0;
    if (block_en) begin
      map_d[block_id] = 1'b1;
    end else if (release_en && (map_q != '0)) begin
      map_d  = '0;
      wake_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      map_q  <= map_d;
      wake_q <= wake_d;
    end
  end

  assert_wake_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (map_q == '0));
  assert_block_records_R4: assert property (@(posedge clk) disable iff (!rst_n)
    block_en |=> map_q[$past(block_id)]);
endmodule

// File: rtl/tfc_tag_ctrl.sv
module tfc_tag_ctrl
  import tfc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int IDW   = 2,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [2:0]    view,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW-1:0] mem_raddr,
  output logic          block_go,
  output logic          ef_done,
  output logic          rsp_valid_q,
  output logic          rsp_blocked_q,
  output logic [DW-1:0] rsp_data_q
);
  localparam int OW = AW + 1;

  logic [AW-1:0] head_q, head_d;
  logic [OW-1:0] occ_q, occ_d;
  logic          e_q, e_d, f_q, f_d, t_q, t_d;
  logic          do_rd, do_wr, upd;
  logic [DW-1:0] rdat;
  logic [DW-1:0] ctrl_word;
  logic [OW-1:0] tail_sum;
  logic [OW-1:0] last_sum;

  assign do_rd    = rd_en;
  assign do_wr    = wr_en && !rd_en;
  assign upd      = rd_en || wr_en;
  assign tail_sum = {1'b0, head_q} + occ_q;
  assign last_sum = tail_sum - OW'(1);
  assign mem_raddr = head_q;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_DEPTH_LSB +: 4] = 4'(AW);
    ctrl_word[CTRL_OCC_LSB +: OW]  = occ_q;
    ctrl_word[CTRL_MODE_BIT]       = 1'b1;
    ctrl_word[CTRL_T_BIT]          = t_q;
    ctrl_word[CTRL_F_BIT]          = f_q;
    ctrl_word[CTRL_E_BIT]          = e_q;
  end

  always_comb begin
    head_d    = head_q;
    occ_d     = occ_q;
    e_d       = e_q;
    f_d       = f_q;
    t_d       = t_q;
    mem_we    = 1'b0;
    mem_waddr = tail_sum[AW-1:0];
    block_go  = 1'b0;
    ef_done   = 1'b0;
    rdat      = '0;
    case (view_e'(view))
      VW_PEEK: begin
        if (do_rd) rdat = mem_rdata;
        if (do_wr && (occ_q != '0)) begin
          mem_we    = 1'b1;
          mem_waddr = last_sum[AW-1:0];
        end
      end
      VW_CTRL: begin
        if (do_rd) rdat = ctrl_word;
        if (do_wr) begin
          t_d = wr_data[CTRL_T_BIT];
          f_d = wr_data[CTRL_F_BIT];
          e_d = wr_data[CTRL_E_BIT];
          if (wr_data[CTRL_E_BIT]) occ_d = '0;
        end
      end
      VW_EF_BLK, VW_EF_TRY: begin
        if (do_rd) begin
          f_d = 1'b0;
          if ((view_e'(view) == VW_EF_BLK) && e_q) begin
            block_go = 1'b1;
          end else begin
            ef_done = 1'b1;
            if (occ_q != '0) begin
              rdat   = mem_rdata;
              head_d = head_q + AW'(1);
              occ_d  = occ_q - OW'(1);
            end
            if (occ_d == '0) e_d = 1'b1;
          end
        end else if (do_wr) begin
          e_d = 1'b0;
          if ((view_e'(view) == VW_EF_BLK) && f_q) begin
            block_go = 1'b1;
          end else begin
            ef_done = 1'b1;
            if (occ_q < OW'(DEPTH)) begin
              mem_we = 1'b1;
              occ_d  = occ_q + OW'(1);
            end
            if (occ_d == OW'(DEPTH)) f_d = 1'b1;
          end
        end
      end
      default: rdat = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      occ_q  <= '0;
      e_q    <= 1'b1;
      f_q    <= 1'b0;
      t_q    <= 1'b0;
    end else if (upd) begin
      head_q <= head_d;
      occ_q  <= occ_d;
      e_q    <= e_d;
      f_q    <= f_d;
      t_q    <= t_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q   <= 1'b0;
      rsp_blocked_q <= 1'b0;
      rsp_data_q    <= '0;
    end else begin
      rsp_valid_q   <= do_rd && !block_go;
      rsp_blocked_q <= block_go;
      if (do_rd) rsp_data_q <= rdat;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OW'(DEPTH));
  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ef_done && do_rd && occ_q != '0) |=> (occ_q == $past(occ_q) - OW'(1)));
  assert_blocked_read_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (block_go && do_rd) |=> ($stable(occ_q) && $stable(head_q) && !f_q));
  assert_peek_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && view == 3'd0) |=> ($stable(occ_q) && $stable(head_q) && $stable(e_q)));
  assert_sem_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && view[2]) |=> ($stable(occ_q) && $stable(head_q) && $stable(e_q) && $stable(f_q)));
endmodule

// File: rtl/tagged_fifo_cell.sv
module tagged_fifo_cell #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int NREQ  = 4,
  parameter int IDW   = $clog2(NREQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [2:0]      view,
  input  logic [DW-1:0]   wr_data,
  input  logic [IDW-1:0]  req_id,
  output logic            rsp_valid,
  output logic            rsp_blocked,
  output logic [DW-1:0]   rsp_data,
  output logic [NREQ-1:0] blocked_map,
  output logic            wake
);
  localparam int AW = $clog2(DEPTH);

  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_rdata;
  logic          block_go, ef_done;

  tfc_storage #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
    .wdata(wr_data), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  tfc_tag_ctrl #(.DW(DW), .DEPTH(DEPTH), .IDW(IDW), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .view(view),
    .wr_data(wr_data), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_raddr(mem_raddr), .block_go(block_go),
    .ef_done(ef_done), .rsp_valid_q(rsp_valid), .rsp_blocked_q(rsp_blocked),
    .rsp_data_q(rsp_data)
  );

  tfc_waitlist #(.NREQ(NREQ), .IDW(IDW)) u_wait (
    .clk(clk), .rst_n(rst_n), .block_en(block_go), .block_id(req_id),
    .release_en(ef_done), .map_q(blocked_map), .wake_q(wake)
  );

  assert_one_reply_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_blocked));
endmodule

// File: tb/tagged_fifo_cell_test.sv
module tagged_fifo_cell_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, DEPTH = 8, NREQ = 4, IDW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0]      view = '0;
  logic [DW-1:0]   wr_data = '0;
  logic [IDW-1:0]  req_id = '0;
  logic            rsp_valid, rsp_blocked, wake;
  logic [DW-1:0]   rsp_data;
  logic [NREQ-1:0] blocked_map;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_fifo_cell #(.DW(DW), .DEPTH(DEPTH), .NREQ(NREQ), .IDW(IDW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .view(view),
    .wr_data(wr_data), .req_id(req_id), .rsp_valid(rsp_valid),
    .rsp_blocked(rsp_blocked), .rsp_data(rsp_data),
    .blocked_map(blocked_map), .wake(wake)
  );

  // reference model
  logic [DW-1:0]   m_mem [DEPTH];
  int              m_head, m_occ;
  bit              m_e, m_f, m_t;
  logic [NREQ-1:0] m_map;

  // scoreboard: {blocked, data}
  logic [DW:0] exp_q [$];
  string       tag_q [$];

  task automatic check(string req, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_head = 0; m_occ = 0; m_e = 1; m_f = 0; m_t = 0; m_map = '0;
  endtask

  task automatic acc(string req, int v, bit rd, bit wr, logic [DW-1:0] d, int id);
    logic [DW-1:0] rv;
    bit blk, cpl, exp_wake;
    rv = '0; blk = 0; cpl = 0; exp_wake = 0;
    @(negedge clk);
    view = 3'(v); rd_en = rd; wr_en = wr; wr_data = d; req_id = IDW'(id);
    if (rd) begin
      case (v)
        0: rv = m_mem[m_head];
        1: rv = (32'(3) << 28) | (32'(m_occ) << 18) | (32'd1 << 17)
               | (32'(m_t) << 16) | (32'(m_f) << 1) | 32'(m_e);
        2, 3: begin
          m_f = 0;
          if (v == 2 && m_e) blk = 1;
          else begin
            cpl = 1;
            if (m_occ > 0) begin
              rv = m_mem[m_head]; m_head = (m_head + 1) % DEPTH; m_occ--;
            end
            if (m_occ == 0) m_e = 1;
          end
        end
        default: rv = '0;
      endcase
    end else if (wr) begin
      case (v)
        0: if (m_occ > 0) m_mem[(m_head + m_occ - 1) % DEPTH] = d;
        1: begin
          m_t = d[16]; m_f = d[1]; m_e = d[0];
          if (d[0]) m_occ = 0;
        end
        2, 3: begin
          m_e = 0;
          if (v == 2 && m_f) blk = 1;
          else begin
            cpl = 1;
            if (m_occ < DEPTH) begin
              m_mem[(m_head + m_occ) % DEPTH] = d; m_occ++;
            end
            if (m_occ == DEPTH) m_f = 1;
          end
        end
        default: ;
      endcase
    end
    if (blk) m_map[id] = 1'b1;
    else if (cpl && m_map != '0) begin m_map = '0; exp_wake = 1; end
    if (blk || rd) begin
      exp_q.push_back({blk, blk ? '0 : rv});
      tag_q.push_back(req);
    end
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    check({req, " wake"}, {32'd0, wake}, {32'd0, exp_wake});
    check({req, " map"}, {29'd0, blocked_map}, {29'd0, m_map});
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && (rsp_valid || rsp_blocked)) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected response actual=%h expected=none", {rsp_blocked, rsp_data});
      end else begin
        logic [DW:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(t, {rsp_blocked, rsp_blocked ? '0 : rsp_data}, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R8: reset state via control word
    check("R1 map", {29'd0, blocked_map}, '0);
    acc("R1 R8 reset ctrl", 1, 1, 0, 0, 0);
    // R3: non-blocking read of empty returns zero
    acc("R3 empty try", 3, 1, 0, 0, 0);
    // R4: blocking read while empty
    acc("R4 block rd", 2, 1, 0, 0, 1);
    acc("R4 ctrl", 1, 1, 0, 0, 0);
    // R6 / R2: completing write wakes
    acc("R6 R2 push", 3, 0, 1, 32'hA0, 0);
    for (int i = 1; i < DEPTH; i++) acc("R2 push", 2, 0, 1, 32'hA0 + i, 0);
    acc("R2 R8 full ctrl", 1, 1, 0, 0, 0);
    // R5: blocking write when full
    acc("R5 block wr", 2, 0, 1, 32'hDEAD, 2);
    acc("R5 ctrl", 1, 1, 0, 0, 0);
    // R13: try write full, wakes, stores nothing
    acc("R13 try full", 3, 0, 1, 32'hBEEF, 3);
    acc("R13 ctrl", 1, 1, 0, 0, 0);
    // R9 peek twice
    acc("R9 peek", 0, 1, 0, 0, 0);
    acc("R9 peek again", 0, 1, 0, 0, 0);
    // R10 overwrite most recent
    acc("R10 patch", 0, 0, 1, 32'hBB, 0);
    for (int i = 0; i < DEPTH; i++) acc("R3 pop", 3, 1, 0, 0, 0);
    acc("R3 empty ctrl", 1, 1, 0, 0, 0);
    // R10 at zero occupancy: no effect
    acc("R10 empty patch", 0, 0, 1, 32'h55, 0);
    acc("R10 peek", 0, 1, 0, 0, 0);
    // wrap: push three, pop two, push more
    acc("R2 wrap", 3, 0, 1, 32'hC0, 0);
    acc("R2 wrap", 3, 0, 1, 32'hC1, 0);
    acc("R2 wrap", 3, 0, 1, 32'hC2, 0);
    acc("R3 wrap", 2, 1, 0, 0, 0);
    acc("R3 wrap", 2, 1, 0, 0, 0);
    for (int i = 0; i < DEPTH - 1; i++) acc("R2 wrap fill", 3, 0, 1, 32'hD0 + i, 0);
    acc("R2 wrap ctrl", 1, 1, 0, 0, 0);
    // R11 semaphore and unused views
    for (int v = 4; v < 8; v++) begin
      acc("R11 read", v, 1, 0, 0, 0);
      acc("R11 write", v, 0, 1, 32'hFFFF_FFFF, 0);
    end
    acc("R11 ctrl", 1, 1, 0, 0, 0);
    acc("R11 peek", 0, 1, 0, 0, 0);
    // R12 simultaneous strobes: read wins
    acc("R12 both", 3, 1, 1, 32'h77, 0);
    acc("R12 ctrl", 1, 1, 0, 0, 0);
    // R7 control write
    acc("R7 set T F", 1, 0, 1, 32'h0001_0002, 0);
    acc("R7 ctrl", 1, 1, 0, 0, 0);
    acc("R7 set E", 1, 0, 1, 32'h0000_0001, 0);
    acc("R7 ctrl cleared", 1, 1, 0, 0, 0);
    acc("R7 try empty", 3, 1, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("scoreboard drained", {31'd0, exp_q.size() != 0}, '0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule